// File: doc/BRIEF.md
# Stack Compare-and-Branch Unit

This block resolves the conditional relative jumps of an evaluation-stack processor. Each operation presents the top stack word (`tos`), the word beneath it (`nos`), a relation code, a signedness flag, a displacement byte and the address of the instruction. One cycle later the block reports whether the branch is taken, the next program counter and how many words the operation removes from the stack.

The four ordering relations run on one carry path. Each relation becomes a two-bit action: add the complement of `nos` to `tos`, or subtract `nos` from `tos`, and then branch either when the carry-out is one or when it is zero. A signed compare inverts the sign bit of both words before the add, so it can reuse the unsigned carry. Equality tests, a zero test on the top word alone, and short forms with a displacement built into the opcode make up the remaining codes.

Top module: `stack_cmp_branch`

## Requirements
- R1: With `is_signed`=0, codes 0, 1, 2 and 3 take the branch when `nos` is less than, less than or equal to, greater than, or greater than or equal to `tos`, comparing the words as unsigned.
- R2: With `is_signed`=1, the same four codes compare `nos` with `tos` as 16-bit two's-complement values.
- R3: The carry decides each ordering result. It is the carry-out of `tos + ~nos + s`, where s=1 for codes 1 and 2. Codes 0 and 1 branch on carry one, and codes 2 and 3 branch on carry zero. As a result, equal operands take codes 1 and 3 and do not take codes 0 and 2.
- R4: Code 4 branches when `nos` equals `tos`. Code 5 branches when they differ. Both use the byte displacement.
- R5: Code 8 (equal) and code 9 (not equal) are one-byte short forms. A taken short branch adds `disp[2:0]+2`, which lies in the range 2 to 9, to `pc_in`.
- R6: Code 6 branches when `tos` is zero, and code 7 branches when `tos` is nonzero. Both report `pop_count`=1, and the value of `nos` has no effect on either.
- R7: Codes 0 to 5, 8 and 9 report `pop_count`=2, whether or not the branch is taken.
- R8: A taken branch with codes 0 to 7 gives `pc_next` = `pc_in` + sign-extended `disp`, modulo 2^16.
- R9: When the branch is not taken, `pc_next` is `pc_in`+2 for codes 0 to 7 and `pc_in`+1 for codes 8 and 9.
- R10: Codes 10 to 15 are reserved. They give `take`=0, `pop_count`=0 and `pc_next`=`pc_in`+1.
- R11: Results are registered. `res_valid` follows `op_valid` one cycle later. In a cycle without a result, `take`=0, `pop_count`=0 and `pc_next` holds its last value.
- R12: While reset is active, `res_valid`, `take`, `pop_count` and `pc_next` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| rel_code | input | 4 | Relation / form selector |
| is_signed | input | 1 | Treat ordering compares as two's complement |
| tos | input | 16 | Top stack word (right operand) |
| nos | input | 16 | Word beneath the top (left operand) |
| disp | input | 8 | Displacement byte |
| pc_in | input | 16 | Address of the branch instruction |
| res_valid | output | 1 | Result registers hold a fresh result |
| take | output | 1 | Branch taken |
| pc_next | output | 16 | Next program counter |
| pop_count | output | 2 | Stack words consumed |

## Verification
Two cases are hard to reach from the ports: words that straddle the sign boundary, where the signed and unsigned answers disagree, and exact ties, where the add-complement and subtract actions differ only through the carry-in. The stimulus crosses eight boundary words (0x0000, 0x0001, 0x7FFE, 0x7FFF, 0x8000, 0x8001, 0xFFFE, 0xFFFF) with every ordering code in both signedness modes, so the sweep covers every tie and every sign crossing. The displacement and PC change on each operation, which sends targets both forward and backward and across the wrap point.

// File: rtl/scb_pkg.sv
package scb_pkg;

  localparam logic [3:0] REL_LT  = 4'd0;
  localparam logic [3:0] REL_LE  = 4'd1;
  localparam logic [3:0] REL_GT  = 4'd2;
  localparam logic [3:0] REL_GE  = 4'd3;
  localparam logic [3:0] REL_EQB = 4'd4;
  localparam logic [3:0] REL_NEB = 4'd5;
  localparam logic [3:0] REL_ZR  = 4'd6;
  localparam logic [3:0] REL_NZ  = 4'd7;
  localparam logic [3:0] REL_EQS = 4'd8;
  localparam logic [3:0] REL_NES = 4'd9;

  typedef enum logic [2:0] {
    K_NONE, K_ORD, K_EQ, K_NE, K_ZR, K_NZ
  } kind_e;

  // Carry-path action: subtract (vs add complement), branch on carry one.
  typedef struct packed {
    logic sub;
    logic on_one;
  } act_t;

endpackage

// File: rtl/scb_decode.sv
module scb_decode
  import scb_pkg::*;
(
  input  logic [3:0] rel_code,
  output act_t       act,
  output kind_e      kind,
  output logic       short_form,
  output logic [1:0] pops
);

  always_comb begin
    act        = '{sub: 1'b0, on_one: 1'b0};
    kind       = K_NONE;
    short_form = 1'b1;
    pops       = 2'd0;
    case (rel_code)
      REL_LT: begin
        act = '{sub: 1'b0, on_one: 1'b1}; kind = K_ORD; short_form = 1'b0; pops = 2'd2;
      end
      REL_LE: begin
        act = '{sub: 1'b1, on_one: 1'b1}; kind = K_ORD; short_form = 1'b0; pops = 2'd2;
      end
      REL_GT: begin
        act = '{sub: 1'b1, on_one: 1'b0}; kind = K_ORD; short_form = 1'b0; pops = 2'd2;
      end
      REL_GE: begin
        act = '{sub: 1'b0, on_one: 1'b0}; kind = K_ORD; short_form = 1'b0; pops = 2'd2;
      end
      REL_EQB: begin kind = K_EQ; short_form = 1'b0; pops = 2'd2; end
      REL_NEB: begin kind = K_NE; short_form = 1'b0; pops = 2'd2; end
      REL_ZR:  begin kind = K_ZR; short_form = 1'b0; pops = 2'd1; end
      REL_NZ:  begin kind = K_NZ; short_form = 1'b0; pops = 2'd1; end
      REL_EQS: begin kind = K_EQ; pops = 2'd2; end
      REL_NES: begin kind = K_NE; pops = 2'd2; end
      default: ;
    endcase
  end

endmodule

// File: rtl/scb_carry_cmp.sv
module scb_carry_cmp
  import scb_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] tos,
  input  logic [W-1:0] nos,
  input  logic         is_signed,
  input  act_t         act,
  output logic         carry
);

  localparam logic [W-1:0] SIGN_BIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] flip;
  logic [W-1:0] a_op;
  logic [W-1:0] b_op;
  logic [W:0]   sum;

  assign flip  = is_signed ? SIGN_BIT : '0;
  assign a_op  = tos ^ flip;
  assign b_op  = nos ^ flip;
  assign sum   = {1'b0, a_op} + {1'b0, ~b_op} + {{W{1'b0}}, act.sub};
  assign carry = |(sum >> W);

endmodule

// File: rtl/scb_target.sv
module scb_target #(
  parameter int PC_W       = 16,
  parameter int DISP_W     = 8,
  parameter int SHORT_W    = 3,
  parameter int SHORT_BASE = 2,
  parameter int BYTE_LEN   = 2,
  parameter int SHORT_LEN  = 1
) (
  input  logic [PC_W-1:0]   pc_in,
  input  logic [DISP_W-1:0] disp,
  input  logic              short_form,
  input  logic              take,
  output logic [PC_W-1:0]   pc_next
);

  localparam int EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] disp_ext;
  logic [PC_W-1:0] short_off;
  logic [PC_W-1:0] step;

  generate
    if (EXT_W > 0) begin : g_extend
      assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    end else begin : g_trunc
      assign disp_ext = disp[PC_W-1:0];
    end
  endgenerate

  assign short_off = PC_W'(disp[SHORT_W-1:0]) + PC_W'(SHORT_BASE);

  always_comb begin
    if (take) step = short_form ? short_off : disp_ext;
    else      step = short_form ? PC_W'(SHORT_LEN) : PC_W'(BYTE_LEN);
  end

  assign pc_next = pc_in + step;

endmodule

// File: rtl/stack_cmp_branch.sv
module stack_cmp_branch
  import scb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PC_W   = 16,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        rel_code,
  input  logic              is_signed,
  input  logic [DATA_W-1:0] tos,
  input  logic [DATA_W-1:0] nos,
  input  logic [DISP_W-1:0] disp,
  input  logic [PC_W-1:0]   pc_in,
  output logic              res_valid,
  output logic              take,
  output logic [PC_W-1:0]   pc_next,
  output logic [1:0]        pop_count
);

  act_t            act;
  kind_e           kind;
  logic            short_form;
  logic [1:0]      pops;
  logic            carry;
  logic            same;
  logic            is_zero;
  logic            cond;
  logic            take_d;
  logic [1:0]      pop_d;
  logic [PC_W-1:0] pc_calc;

  scb_decode u_dec (
    .rel_code   (rel_code),
    .act        (act),
    .kind       (kind),
    .short_form (short_form),
    .pops       (pops)
  );

  scb_carry_cmp #(.W(DATA_W)) u_cmp (
    .tos       (tos),
    .nos       (nos),
    .is_signed (is_signed),
    .act       (act),
    .carry     (carry)
  );

  assign same    = (tos == nos);
  assign is_zero = (tos == '0);

  always_comb begin
    case (kind)
      K_ORD:   cond = (carry == act.on_one);
      K_EQ:    cond = same;
      K_NE:    cond = !same;
      K_ZR:    cond = is_zero;
      K_NZ:    cond = !is_zero;
      default: cond = 1'b0;
    endcase
  end

  scb_target #(.PC_W(PC_W), .DISP_W(DISP_W)) u_tgt (
    .pc_in      (pc_in),
    .disp       (disp),
    .short_form (short_form),
    .take       (cond),
    .pc_next    (pc_calc)
  );

  // Next-state
  assign take_d = op_valid & cond;
  assign pop_d  = op_valid ? pops : 2'd0;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      take      <= 1'b0;
      pop_count <= 2'd0;
      pc_next   <= '0;
    end else begin
      res_valid <= op_valid;
      take      <= take_d;
      pop_count <= pop_d;
      if (op_valid) pc_next <= pc_calc;
    end
  end

  // R11
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(op_valid));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!take && pop_count == 2'd0));

  // R7
  two_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && ($past(rel_code) < 4'd6 || $past(rel_code) == 4'd8 ||
                   $past(rel_code) == 4'd9)) |-> pop_count == 2'd2);

  // R6
  one_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && ($past(rel_code) == 4'd6 || $past(rel_code) == 4'd7))
      |-> pop_count == 2'd1);

  // R4
  eq_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(rel_code) == 4'd4 && $past(tos) != $past(nos)) |-> !take);

  // R3
  tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(rel_code) < 4'd4 && $past(tos) == $past(nos))
      |-> take == $past(rel_code[0]));

  // R10
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(rel_code) >= 4'd10) |-> (!take && pop_count == 2'd0));

endmodule

// File: tb/sim_stack_cmp_branch.sv
module sim_stack_cmp_branch;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  rel_code;
  logic        is_signed;
  logic [15:0] tos, nos;
  logic [7:0]  disp;
  logic [15:0] pc_in;
  logic        res_valid, take;
  logic [15:0] pc_next;
  logic [1:0]  pop_count;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h7FFE, 16'h7FFF,
                            16'h8000, 16'h8001, 16'hFFFE, 16'hFFFF};

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_cmp_branch u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .rel_code(rel_code),
    .is_signed(is_signed), .tos(tos), .nos(nos), .disp(disp), .pc_in(pc_in),
    .res_valid(res_valid), .take(take), .pc_next(pc_next), .pop_count(pop_count)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_take(logic [3:0] r, logic s, logic [15:0] t, logic [15:0] n);
    case (r)
      4'd0: return s ? ($signed(n) <  $signed(t)) : (n <  t);
      4'd1: return s ? ($signed(n) <= $signed(t)) : (n <= t);
      4'd2: return s ? ($signed(n) >  $signed(t)) : (n >  t);
      4'd3: return s ? ($signed(n) >= $signed(t)) : (n >= t);
      4'd4, 4'd8: return n == t;
      4'd5, 4'd9: return n != t;
      4'd6: return t == 16'h0;
      4'd7: return t != 16'h0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run_op(logic [3:0] r, logic s, logic [15:0] t, logic [15:0] n,
                        logic [7:0] d, logic [15:0] p);
    logic        et;
    logic [1:0]  ep;
    logic [15:0] epc;
    string       treq;
    @(negedge clk);
    op_valid = 1'b1; rel_code = r; is_signed = s; tos = t; nos = n; disp = d; pc_in = p;
    @(negedge clk);
    et = exp_take(r, s, t, n);
    if (r < 4'd6 || r == 4'd8 || r == 4'd9) ep = 2'd2;
    else if (r < 4'd8) ep = 2'd1;
    else ep = 2'd0;
    if (r < 4'd8) epc = et ? p + {{8{d[7]}}, d} : p + 16'd2;
    else if (r < 4'd10) epc = et ? p + {13'd0, d[2:0]} + 16'd2 : p + 16'd1;
    else epc = p + 16'd1;
    if (r < 4'd4) treq = (t == n) ? "R3" : (s ? "R2" : "R1");
    else if (r < 4'd6) treq = "R4";
    else if (r < 4'd8) treq = "R6";
    else if (r < 4'd10) treq = "R5";
    else treq = "R10";
    chk("R11", "res_valid", {31'd0, res_valid}, 32'd1);
    chk(treq, "take", {31'd0, take}, {31'd0, et});
    chk((r >= 4'd10) ? "R10" : ((r == 4'd6 || r == 4'd7) ? "R6" : "R7"),
        "pop_count", {30'd0, pop_count}, {30'd0, ep});
    chk((r >= 4'd10) ? "R10" : ((r >= 4'd8) ? (et ? "R5" : "R9") : (et ? "R8" : "R9")),
        "pc_next", {16'd0, pc_next}, {16'd0, epc});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL R11 watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] last_pc;
    int k;
    rst_n = 1'b0; op_valid = 1'b0; rel_code = 4'd0; is_signed = 1'b0;
    tos = 16'h0; nos = 16'h0; disp = 8'h0; pc_in = 16'h0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "res_valid", {31'd0, res_valid}, 32'd0);
    chk("R12", "take", {31'd0, take}, 32'd0);
    chk("R12", "pop_count", {30'd0, pop_count}, 32'd0);
    chk("R12", "pc_next", {16'd0, pc_next}, 32'd0);
    rst_n = 1'b1;
    k = 0;
    // R1 R2 R3 ordering sweep
    for (int s = 0; s < 2; s++)
      for (int r = 0; r < 4; r++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++) begin
            run_op(4'(r), 1'(s), vals[i], vals[j], 8'(k * 37), 16'(16'hFFC0 + k * 7));
            k++;
          end
    // R4 R5 equality, byte and short forms
    for (int r = 4; r < 10; r += (r == 5) ? 3 : 1)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          run_op(4'(r), 1'(k), vals[i], vals[j], 8'(k * 53), 16'(16'h0F00 + k * 11));
          k++;
        end
    // R6 zero tests: nos varies, only tos matters
    for (int r = 6; r < 8; r++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          run_op(4'(r), 1'b0, vals[i], vals[j], 8'(k * 29), 16'(16'h4000 + k * 3));
          k++;
        end
    // R10 reserved codes with operands that would branch elsewhere
    for (int r = 10; r < 16; r++) begin
      run_op(4'(r), 1'b0, 16'h0000, 16'h0000, 8'h80, 16'hFFFF);
      run_op(4'(r), 1'b1, 16'h1234, 16'h8000, 8'h7F, 16'h2000);
    end
    // R11 idle cycle: no result, pc_next holds
    last_pc = pc_next;
    @(negedge clk);
    op_valid = 1'b0; rel_code = 4'd4; tos = 16'h0; nos = 16'h0; pc_in = 16'h5555;
    @(negedge clk);
    chk("R11", "idle res_valid", {31'd0, res_valid}, 32'd0);
    chk("R11", "idle take", {31'd0, take}, 32'd0);
    chk("R11", "idle pop_count", {30'd0, pop_count}, 32'd0);
    chk("R11", "idle pc_next", {16'd0, pc_next}, {16'd0, last_pc});
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule